// File: doc/BRIEF.md
# SCL Phase and Strobe Timer

This block paces the clock line of a two-wire serial master. One 32-bit divider word sets two counts: the lower half sets the low-phase count and the upper half sets the high-phase count. Each SCL phase is split into eight equal steps, and each step lasts one count of input clocks. A full SCL period is therefore eight times the sum of the two counts. Equal counts give a 50% duty cycle. To reach a target rate, set each count to half of fclk/(8·fscl), rounding up at both divisions. The intended range is 10 kHz to 400 kHz.

Besides the SCL level, the timer gives the bus engine single-cycle strobes:
- one telling it when SDA may change;
- one telling it when SDA is sampled;
- one at each phase boundary, so start, stop and repeated-start conditions can be placed.

The engine can freeze the timer with a hold input. A slave that keeps SCL low after the master releases it pauses the high phase, which gives basic clock stretching.

Top module: `scl_timing_gen`

## Requirements
- R1: While `enable` is low, `scl_out` is 1 (released) and every strobe is 0. The next cycle with `enable` high is the first cycle of a low phase.
- R2: `div_word[15:0]` is the low count L and `div_word[31:16]` is the high count H. The low phase (`scl_out`=0) lasts 8·L advancing cycles and the high phase (`scl_out`=1) lasts 8·H advancing cycles.
- R3: Successive `low_begin` pulses are 8·(L+H) cycles apart when nothing holds or stretches.
- R4: A count field of zero behaves exactly like a count of one.
- R5: `sda_upd` pulses once per period, on the last cycle of the first step of the low phase: the L-th cycle of that phase.
- R6: `smp_strobe` pulses once per period, at the middle of the high phase: 4·H cycles after `high_begin`.
- R7: `low_begin` marks the first cycle of each low phase, `high_begin` the first cycle of each high phase, and `high_end` the last cycle of each high phase. At most one of `low_begin`, `high_begin`, `smp_strobe` and `high_end` is high in any cycle.
- R8: The divider word is taken only on the first cycle of a low phase. A change at any other time has no effect until the next low phase begins.
- R9: If `scl_in` is 0 while `scl_out` is 1, the high phase does not advance and no strobe fires. `scl_out` stays 1.
- R10: While `hold` is 1, the timer does not advance, `scl_out` keeps its level and no strobe fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the timer; low returns it to the idle released state |
| div_word | input | 32 | Divider word: low count in [15:0], high count in [31:16] |
| hold | input | 1 | Freeze request from the bus engine |
| scl_in | input | 1 | Sensed level of the SCL line |
| scl_out | output | 1 | SCL drive level: 0 pulls low, 1 releases |
| sda_upd | output | 1 | Strobe: SDA may change now |
| smp_strobe | output | 1 | Strobe: sample SDA now |
| low_begin | output | 1 | First cycle of a low phase |
| high_begin | output | 1 | First cycle of a high phase |
| high_end | output | 1 | Last cycle of a high phase |

## Verification
The timer is driven with several divider patterns: equal counts, strongly unequal counts, a large low count and all-zero fields. Comparing these separates a swapped or mis-scaled half from a correct one, and shows whether a zero count collapses to one. The divider word is rewritten in the middle of periods to show whether it is taken anywhere other than the first low cycle. Hold pulses and slave stretches are injected in both phases and at the strobe points. This shows whether a freeze drops or repeats a strobe, and whether a stretch is wrongly honoured during the low phase. A disable and re-enable in the middle of a run confirms the restart from the idle state.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } sclk_phase_e;

    typedef struct packed {
        logic low_begin;
        logic sda_upd;
        logic high_begin;
        logic smp;
        logic high_end;
    } sclk_evt_t;

endpackage

// File: rtl/sclk_div_latch.sv
module sclk_div_latch #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [2*CNT_W-1:0] div_word,
    output logic [CNT_W-1:0] lo_eff,
    output logic [CNT_W-1:0] hi_eff
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] lo_new, hi_new, lo_q, hi_q;

    // zero counts are promoted to one so the line never stalls
    always_comb begin
        lo_new = (div_word[CNT_W-1:0] == '0) ? ONE : div_word[CNT_W-1:0];
        hi_new = (div_word[2*CNT_W-1:CNT_W] == '0) ? ONE : div_word[2*CNT_W-1:CNT_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= ONE;
            hi_q <= ONE;
        end else if (load) begin
            lo_q <= lo_new;
            hi_q <= hi_new;
        end
    end

    // on the loading cycle the fresh value is already in force
    assign lo_eff = load ? lo_new : lo_q;
    assign hi_eff = load ? hi_new : hi_q;
endmodule

// File: rtl/sclk_phase_ctr.sv
module sclk_phase_ctr
    import sclk_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned STEPS  = 8,
    localparam int unsigned STEP_W = $clog2(STEPS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              adv,
    input  logic [CNT_W-1:0]  lim_lo,
    input  logic [CNT_W-1:0]  lim_hi,
    output sclk_phase_e       phase,
    output logic [STEP_W-1:0] step,
    output logic [CNT_W-1:0]  cnt
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

    logic [CNT_W-1:0] lim;
    logic             step_done;

    assign lim       = (phase == PH_LOW) ? lim_lo : lim_hi;
    assign step_done = (cnt == lim - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase <= PH_LOW;
            step  <= '0;
            cnt   <= '0;
        end else if (adv) begin
            if (step_done) begin
                cnt <= '0;
                if (step == LAST_STEP) begin
                    step  <= '0;
                    phase <= (phase == PH_LOW) ? PH_HIGH : PH_LOW;
                end else begin
                    step <= step + STEP_W'(1);
                end
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import sclk_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned STEPS = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic [2*CNT_W-1:0] div_word,
    input  logic               hold,
    input  logic               scl_in,
    output logic               scl_out,
    output logic               sda_upd,
    output logic               smp_strobe,
    output logic               low_begin,
    output logic               high_begin,
    output logic               high_end
);
    localparam int unsigned STEP_W = $clog2(STEPS);
    localparam logic [STEP_W-1:0] MID_STEP  = STEP_W'(STEPS / 2);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

    sclk_phase_e       phase;
    logic [STEP_W-1:0] step;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  lo_eff, hi_eff;
    logic              at_low_start, stretched, adv;
    sclk_evt_t         evt;

    assign at_low_start = (phase == PH_LOW) && (step == '0) && (cnt == '0);
    assign stretched    = (phase == PH_HIGH) && !scl_in;
    assign adv          = enable && !hold && !stretched;

    sclk_div_latch #(.CNT_W(CNT_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .load     (adv && at_low_start),
        .div_word (div_word),
        .lo_eff   (lo_eff),
        .hi_eff   (hi_eff)
    );

    sclk_phase_ctr #(.CNT_W(CNT_W), .STEPS(STEPS)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .clr    (!enable),
        .adv    (adv),
        .lim_lo (lo_eff),
        .lim_hi (hi_eff),
        .phase  (phase),
        .step   (step),
        .cnt    (cnt)
    );

    always_comb begin
        evt            = '0;
        evt.low_begin  = at_low_start;
        evt.sda_upd    = (phase == PH_LOW) && (step == '0) && (cnt == lo_eff - CNT_W'(1));
        evt.high_begin = (phase == PH_HIGH) && (step == '0) && (cnt == '0);
        evt.smp        = (phase == PH_HIGH) && (step == MID_STEP) && (cnt == '0);
        evt.high_end   = (phase == PH_HIGH) && (step == LAST_STEP) && (cnt == hi_eff - CNT_W'(1));
        if (!adv) evt = '0;
    end

    assign scl_out    = !enable || (phase == PH_HIGH);
    assign sda_upd    = evt.sda_upd;
    assign smp_strobe = evt.smp;
    assign low_begin  = evt.low_begin;
    assign high_begin = evt.high_begin;
    assign high_end   = evt.high_end;
endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic hold,
    input logic scl_in,
    input logic scl_out,
    input logic sda_upd,
    input logic smp_strobe,
    input logic low_begin,
    input logic high_begin,
    input logic high_end
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !enable |-> (scl_out && !sda_upd && !smp_strobe && !low_begin && !high_begin && !high_end));

    a_r5_update_while_low: assert property (@(posedge clk) disable iff (rst)
        sda_upd |-> !scl_out);

    a_r6_sample_while_high: assert property (@(posedge clk) disable iff (rst)
        smp_strobe |-> (scl_out && scl_in));

    a_r7_low_follows_high: assert property (@(posedge clk) disable iff (rst)
        (high_end && enable) |=> (low_begin || !enable || hold));

    a_r7_one_boundary: assert property (@(posedge clk) disable iff (rst)
        $onehot0({low_begin, high_begin, smp_strobe, high_end}));

    a_r9_stretch_keeps_high: assert property (@(posedge clk) disable iff (rst)
        (enable && scl_out && !scl_in) |=> (scl_out || !enable));

    a_r10_hold_freezes: assert property (@(posedge clk) disable iff (rst)
        (enable && hold) |=> ($stable(scl_out) || !enable));
endmodule

bind scl_timing_gen scl_timing_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .hold       (hold),
    .scl_in     (scl_in),
    .scl_out    (scl_out),
    .sda_upd    (sda_upd),
    .smp_strobe (smp_strobe),
    .low_begin  (low_begin),
    .high_begin (high_begin),
    .high_end   (high_end)
);

// File: tb/scl_timing_gen_tb_top.sv
module scl_timing_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [31:0] div_word = 32'h0002_0002;
    logic        hold = 1'b0;
    logic        ext_low = 1'b0;
    logic        scl_in;
    logic        scl_out, sda_upd, smp_strobe, low_begin, high_begin, high_end;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    int pos = 0;
    int mlo = 1;
    int mhi = 1;
    int last_lb = -1;
    int per_exp = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign scl_in = scl_out && !ext_low;

    scl_timing_gen dut_i (
        .clk(clk), .rst(rst), .enable(enable), .div_word(div_word),
        .hold(hold), .scl_in(scl_in), .scl_out(scl_out), .sda_upd(sda_upd),
        .smp_strobe(smp_strobe), .low_begin(low_begin),
        .high_begin(high_begin), .high_end(high_end)
    );

    function automatic int sat1(int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic chk(string req, logic act, logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %b expected %b", req, cyc, act, exp);
        end
    endtask

    task automatic chk_int(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // one cycle: compare outputs against the position model, then advance it
    task automatic tick();
        int lo_c, hi_c, per;
        bit e_scl, m_adv;
        #1;
        lo_c  = (pos == 0) ? sat1(int'(div_word[15:0]))  : mlo;
        hi_c  = (pos == 0) ? sat1(int'(div_word[31:16])) : mhi;
        per   = 8 * (lo_c + hi_c);
        e_scl = !enable || (pos >= 8 * lo_c);
        m_adv = enable && !hold && !((pos >= 8 * lo_c) && !(e_scl && !ext_low));
        chk("R2 scl level", scl_out, e_scl);
        chk("R5 sda_upd", sda_upd, m_adv && pos == lo_c - 1);
        chk("R6 smp_strobe", smp_strobe, m_adv && pos == 8 * lo_c + 4 * hi_c);
        chk("R7 low_begin", low_begin, m_adv && pos == 0);
        chk("R7 high_begin", high_begin, m_adv && pos == 8 * lo_c);
        chk("R7 high_end", high_end, m_adv && pos == per - 1);
        if (low_begin && per_exp != 0) begin
            if (last_lb >= 0) chk_int("R3 period", cyc - last_lb, per_exp);
            last_lb = cyc;
        end
        @(posedge clk);
        cyc++;
        if (!enable) pos = 0;
        else if (m_adv) begin
            if (pos == 0) begin mlo = lo_c; mhi = hi_c; end
            pos++;
            if (pos == per) pos = 0;
        end
        @(negedge clk);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset / idle state
        chk("R1 reset scl", scl_out, 1'b1);
        chk("R1 reset strobes", |{sda_upd, smp_strobe, low_begin, high_begin, high_end}, 1'b0);
        rst = 1'b0;
        run(4);
        // R2 R3: equal counts 2/2, period 32
        enable = 1'b1; per_exp = 32;
        run(100);
        // R2 R3: unequal counts 3/1, period 32
        enable = 1'b0; run(2);
        last_lb = -1; div_word = 32'h0001_0003; enable = 1'b1;
        run(100);
        // R8: rewrite the divider in mid period
        per_exp = 0;
        run(5); div_word = 32'h0004_0001; run(20); div_word = 32'h0002_0005; run(150);
        // R4: zero fields behave as one
        enable = 1'b0; run(2);
        last_lb = -1; div_word = 32'h0000_0000; per_exp = 16; enable = 1'b1;
        run(60);
        // larger low count, R3
        enable = 1'b0; run(2);
        last_lb = -1; div_word = 32'h0003_0014; per_exp = 184; enable = 1'b1;
        run(400);
        // R10: hold pulses at many positions
        per_exp = 0; div_word = 32'h0002_0001;
        for (int k = 0; k < 30; k++) begin
            hold = 1'b1; run(1 + (k % 3)); hold = 1'b0; run(3 + k);
        end
        // R9: stretch requests in both phases
        for (int k = 0; k < 25; k++) begin
            ext_low = 1'b1; run(2 + (k % 4)); ext_low = 1'b0; run(5 + k);
        end
        // R1: disable mid-run then restart
        run(7); enable = 1'b0; run(3);
        chk("R1 idle scl", scl_out, 1'b1);
        enable = 1'b1; run(60);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (WATCHDOG) @(posedge clk);
                n_bad++;
                $display("FAIL watchdog expired: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule